// File: doc/BRIEF.md
# Modem Control and Status Unit

This unit is the modem side of a serial port controller. It holds the modem control register, which drives four modem output pins and a loopback flag. It also keeps the modem status register. That register shows the current state of four modem input lines (clear-to-send, data-set-ready, ring, carrier detect) together with four sticky change flags. External lines pass through a two-flop synchronizer before they are compared with the last sampled state. With the loopback flag set, the control bits replace the external lines, using a fixed mapping.

A host writes the control register through a write strobe and a data byte. It reads the status register by sampling `status_q` in the cycle where it pulses `rd_status`; the change flags clear at that edge. The interrupt source `msi_req` feeds the port's interrupt priority logic and stays high while any change flag is set.

Top module: `modem_ctl_status`

## Requirements
- R1: After a synchronous reset `status_q` is 0xB0 (carrier detect, data-set-ready and clear-to-send high, ring low, no change flags) and `ctrl_q` is 0x08 (only OUT2 set). `msi_req` and `loop_en` are low.
- R2: In `status_q`, bits 7..4 are carrier detect, ring, data-set-ready and clear-to-send. A transition in either direction of carrier detect, data-set-ready or clear-to-send sets bit 3, bit 1 or bit 0 respectively. Each flag stays set until a status read.
- R3: Bit 2, the ring change flag, is set only when the ring line goes from 1 to 0. A 0-to-1 ring transition leaves it unchanged.
- R4: `status_q` in a cycle with `rd_status` high is the value before the read. At that edge bits 3..0 clear, and bits 7..4 are not affected.
- R5: If a line change reaches the status register on the same edge as a read, its change flag is set after that edge. Older flags are cleared.
- R6: `msi_req` is high exactly when any of `status_q[3:0]` is set.
- R7: A change on an external modem line first appears in `status_q` after the third rising clock edge that follows it.
- R8: While `ctrl_q[4]` is set, the line state is taken from the control register instead of the external lines: carrier detect from bit 3, ring from bit 2, clear-to-send from bit 1, data-set-ready from bit 0. External lines are then ignored. The new mapping reaches `status_q` one edge after the write edge. Transitions it causes set change flags by R2 and R3.
- R9: A control write stores `wr_data[4:0]`, and `ctrl_q[7:5]` always reads zero. `pin_dtr`, `pin_rts`, `pin_out1`, `pin_out2` and `loop_en` follow control bits 0, 1, 2, 3 and 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_ctrl | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control register write data |
| rd_status | input | 1 | Status read strobe, clears change flags |
| line_cts | input | 1 | Clear-to-send input, asynchronous |
| line_dsr | input | 1 | Data-set-ready input, asynchronous |
| line_ri | input | 1 | Ring input, asynchronous |
| line_dcd | input | 1 | Carrier detect input, asynchronous |
| status_q | output | 8 | Modem status register |
| ctrl_q | output | 8 | Modem control register readback |
| pin_dtr | output | 1 | Data-terminal-ready output |
| pin_rts | output | 1 | Request-to-send output |
| pin_out1 | output | 1 | General output 1 |
| pin_out2 | output | 1 | General output 2 |
| loop_en | output | 1 | Loopback mode flag |
| msi_req | output | 1 | Modem status interrupt source |

## Verification
The bench checks each ring edge in both directions. A design that decoded both edges would flag the rising edge, and one with an inverted edge would miss the falling one.

It places a read on the exact edge where a new change lands. A design that gave the clear priority would lose that change.

It enters and leaves loopback with mixed control patterns and disturbs the external lines during loopback. This exposes a swapped clear-to-send/data-set-ready mapping or leakage from the external lines.

Samples are taken on the cycles just before and just after the synchronizer delay. A missing or extra stage shows up as an early or late status change.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
  localparam int NLINES = 4;
  localparam int DATA_W = 8;
  localparam int CTL_W  = 5;

  // control register bit positions
  localparam int CTL_DTR  = 0;
  localparam int CTL_RTS  = 1;
  localparam int CTL_OUT1 = 2;
  localparam int CTL_OUT2 = 3;
  localparam int CTL_LOOP = 4;

  // change flag positions inside the low nibble of the status register
  localparam int DF_CTS  = 0;
  localparam int DF_DSR  = 1;
  localparam int DF_TERI = 2;
  localparam int DF_DCD  = 3;

  typedef struct packed {
    logic dcd;
    logic ri;
    logic dsr;
    logic cts;
  } mdm_lines_t;

  localparam mdm_lines_t LINES_RST = '{dcd: 1'b1, ri: 1'b0, dsr: 1'b1, cts: 1'b1};
  localparam logic [CTL_W-1:0] CTL_RST = 5'b01000;
endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] pipe;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) pipe[g] <= RST_VAL;
        else     pipe[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) pipe[g] <= RST_VAL;
        else     pipe[g] <= pipe[g-1];
      end
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/mdm_ctrl_reg.sv
module mdm_ctrl_reg #(
  parameter int DATA_W = 8,
  parameter int CTL_W  = 5,
  parameter logic [CTL_W-1:0] RST_VAL = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [DATA_W-1:0] data,
  output logic [CTL_W-1:0]  ctl,
  output logic [DATA_W-1:0] rd_val
);
  localparam int PAD_W = DATA_W - CTL_W;

  logic unused_hi;
  assign unused_hi = ^data[DATA_W-1:CTL_W];

  always_ff @(posedge clk) begin
    if (rst)     ctl <= RST_VAL;
    else if (wr) ctl <= data[CTL_W-1:0];
  end

  assign rd_val = {{PAD_W{1'b0}}, ctl};

  assert_ctrl_store_R9: assert property (@(posedge clk) disable iff (rst)
    wr |=> (ctl == $past(data[CTL_W-1:0])));

  assert_ctrl_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !wr |=> $stable(ctl));
endmodule

// File: rtl/mdm_status_core.sv
module mdm_status_core
  import mdm_pkg::*;
#(
  parameter int NL = NLINES
) (
  input  logic          clk,
  input  logic          rst,
  input  mdm_lines_t    src,
  input  logic          rd_clr,
  output mdm_lines_t    lines_q,
  output logic [NL-1:0] delta_q
);
  logic [NL-1:0] chg;

  always_comb begin
    chg          = '0;
    chg[DF_CTS]  = lines_q.cts ^ src.cts;
    chg[DF_DSR]  = lines_q.dsr ^ src.dsr;
    chg[DF_DCD]  = lines_q.dcd ^ src.dcd;
    chg[DF_TERI] = lines_q.ri & ~src.ri;   // trailing edge of ring only
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lines_q <= LINES_RST;
      delta_q <= '0;
    end else begin
      lines_q <= src;
      delta_q <= (rd_clr ? '0 : delta_q) | chg;
    end
  end

  assert_sticky_R2: assert property (@(posedge clk) disable iff (rst)
    !rd_clr |=> ((delta_q & $past(delta_q)) == $past(delta_q)));

  assert_cts_change_R2: assert property (@(posedge clk) disable iff (rst)
    (lines_q.cts != src.cts) |=> delta_q[DF_CTS]);

  assert_teri_fall_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(delta_q[DF_TERI]) |-> $fell(lines_q.ri));

  assert_no_teri_rise_R3: assert property (@(posedge clk) disable iff (rst)
    (!lines_q.ri && src.ri && !delta_q[DF_TERI] && !rd_clr) |=> !delta_q[DF_TERI]);

  assert_read_clear_R4: assert property (@(posedge clk) disable iff (rst)
    (rd_clr && (src == lines_q)) |=> (delta_q == '0));

  assert_read_keeps_lines_R4: assert property (@(posedge clk) disable iff (rst)
    rd_clr |=> (lines_q == $past(src)));
endmodule

// File: rtl/modem_ctl_status.sv
module modem_ctl_status
  import mdm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_ctrl,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_status,
  input  logic              line_cts,
  input  logic              line_dsr,
  input  logic              line_ri,
  input  logic              line_dcd,
  output logic [DATA_W-1:0] status_q,
  output logic [DATA_W-1:0] ctrl_q,
  output logic              pin_dtr,
  output logic              pin_rts,
  output logic              pin_out1,
  output logic              pin_out2,
  output logic              loop_en,
  output logic              msi_req
);
  mdm_lines_t       ext_raw, ext_sync, src, lines_q, loop_lines;
  logic [CTL_W-1:0] ctl;
  logic [NLINES-1:0] delta_q;

  assign ext_raw = '{dcd: line_dcd, ri: line_ri, dsr: line_dsr, cts: line_cts};

  mdm_sync #(.WIDTH(NLINES), .STAGES(SYNC_STAGES), .RST_VAL(LINES_RST)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (ext_raw),
    .q   (ext_sync)
  );

  mdm_ctrl_reg #(.DATA_W(DATA_W), .CTL_W(CTL_W), .RST_VAL(CTL_RST)) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .wr     (wr_ctrl),
    .data   (wr_data),
    .ctl    (ctl),
    .rd_val (ctrl_q)
  );

  // fixed loopback routing of control bits onto status lines
  assign loop_lines = '{dcd: ctl[CTL_OUT2], ri: ctl[CTL_OUT1],
                        dsr: ctl[CTL_DTR],  cts: ctl[CTL_RTS]};
  assign src = ctl[CTL_LOOP] ? loop_lines : ext_sync;

  mdm_status_core #(.NL(NLINES)) u_core (
    .clk     (clk),
    .rst     (rst),
    .src     (src),
    .rd_clr  (rd_status),
    .lines_q (lines_q),
    .delta_q (delta_q)
  );

  assign status_q = {lines_q, delta_q};
  assign msi_req  = |delta_q;
  assign pin_dtr  = ctl[CTL_DTR];
  assign pin_rts  = ctl[CTL_RTS];
  assign pin_out1 = ctl[CTL_OUT1];
  assign pin_out2 = ctl[CTL_OUT2];
  assign loop_en  = ctl[CTL_LOOP];

  assert_loop_map_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(ctrl_q[CTL_LOOP])) |->
      (status_q[7:4] == {$past(ctrl_q[CTL_OUT2]), $past(ctrl_q[CTL_OUT1]),
                         $past(ctrl_q[CTL_DTR]),  $past(ctrl_q[CTL_RTS])}));

  assert_msi_drop_R6: assert property (@(posedge clk) disable iff (rst)
    (rd_status && (src == lines_q)) |=> !msi_req);
endmodule

// File: tb/modem_ctl_status_test.sv
module modem_ctl_status_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_ctrl = 1'b0;
  logic [7:0] wr_data = '0;
  logic rd_status = 1'b0;
  logic [3:0] ext = 4'b1011;   // {dcd, ri, dsr, cts}
  logic [7:0] status_q, ctrl_q;
  logic pin_dtr, pin_rts, pin_out1, pin_out2, loop_en, msi_req;

  int total = 0;
  int fails = 0;

  // bench model state
  logic [3:0] m_s1, m_s2, m_cur, m_d;
  logic [4:0] m_ctl;

  always #10 clk = ~clk;

  modem_ctl_status uut (
    .clk(clk), .rst(rst), .wr_ctrl(wr_ctrl), .wr_data(wr_data),
    .rd_status(rd_status),
    .line_cts(ext[0]), .line_dsr(ext[1]), .line_ri(ext[2]), .line_dcd(ext[3]),
    .status_q(status_q), .ctrl_q(ctrl_q),
    .pin_dtr(pin_dtr), .pin_rts(pin_rts), .pin_out1(pin_out1), .pin_out2(pin_out2),
    .loop_en(loop_en), .msi_req(msi_req)
  );

  function automatic logic [3:0] line_src(logic [4:0] c, logic [3:0] s2);
    return c[4] ? {c[3], c[2], c[0], c[1]} : s2;
  endfunction

  function automatic logic [3:0] change_of(logic [3:0] o, logic [3:0] n);
    return {o[3] ^ n[3], o[2] & ~n[2], o[1] ^ n[1], o[0] ^ n[0]};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    logic [3:0] src, n_d;
    logic [4:0] n_ctl;
    if (rst) begin
      m_s1 = 4'b1011; m_s2 = 4'b1011; m_cur = 4'b1011; m_d = '0; m_ctl = 5'b01000;
      @(posedge clk);
    end else begin
      src   = line_src(m_ctl, m_s2);
      n_d   = (rd_status ? 4'b0 : m_d) | change_of(m_cur, src);
      n_ctl = wr_ctrl ? wr_data[4:0] : m_ctl;
      @(posedge clk);
      m_s2 = m_s1; m_s1 = ext; m_cur = src; m_d = n_d; m_ctl = n_ctl;
    end
    @(negedge clk);
  endtask

  task automatic compare_all(string tag);
    check({tag, " status"}, status_q, {m_cur, m_d});
    check({tag, " ctrl R9"}, ctrl_q, {3'b000, m_ctl});
    check({tag, " msi R6"}, msi_req, |m_d);
    check({tag, " pins R9"}, {loop_en, pin_out2, pin_out1, pin_rts, pin_dtr}, m_ctl);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    ticks(3);
    rst = 1'b0;
    tick();
    // R1 reset state
    check("R1 status", status_q, 8'hB0);
    check("R1 ctrl", ctrl_q, 8'h08);
    check("R1 msi", msi_req, 1'b0);
    check("R1 pins", {loop_en, pin_out2, pin_out1, pin_rts, pin_dtr}, 5'b01000);

    // R7 synchronizer delay, R2 change flag
    ext = 4'b1010;
    ticks(2);
    check("R7 not yet", status_q, 8'hB0);
    tick();
    check("R7 R2 cts fall", status_q, 8'hA1);
    check("R6 msi set", msi_req, 1'b1);

    // R4 read
    rd_status = 1'b1;
    check("R4 pre-read value", status_q, 8'hA1);
    tick();
    rd_status = 1'b0;
    check("R4 cleared", status_q, 8'hA0);
    check("R6 msi cleared", msi_req, 1'b0);

    // R3 ring edges
    ext = 4'b1110;
    ticks(3);
    check("R3 ring rise no flag", status_q, 8'hE0);
    ext = 4'b1010;
    ticks(3);
    check("R3 ring fall flag", status_q, 8'hA4);

    // R5 read coincides with new change
    ext = 4'b1011;
    ticks(2);
    rd_status = 1'b1;
    tick();
    rd_status = 1'b0;
    check("R5 new change kept", status_q, 8'hB1);
    rd_status = 1'b1;
    tick();
    rd_status = 1'b0;
    check("R4 clear again", status_q, 8'hB0);

    // R9 write with high bits, R8 loopback
    wr_ctrl = 1'b1; wr_data = 8'hFF;
    tick();
    wr_ctrl = 1'b0;
    check("R9 high bits zero", ctrl_q, 8'h1F);
    check("R9 pins", {loop_en, pin_out2, pin_out1, pin_rts, pin_dtr}, 5'b11111);
    check("R8 not yet", status_q, 8'hB0);
    tick();
    check("R8 loop all ones", status_q, 8'hF0);
    ext = 4'b0000;
    ticks(4);
    check("R8 external ignored", status_q, 8'hF0);
    wr_ctrl = 1'b1; wr_data = 8'h12;
    tick();
    wr_ctrl = 1'b0;
    tick();
    check("R8 rts to cts mapping", status_q, 8'h1E);
    check("R8 msi", msi_req, 1'b1);
    wr_ctrl = 1'b1; wr_data = 8'h08;
    tick();
    wr_ctrl = 1'b0;
    tick();
    check("R8 leave loopback", status_q, 8'h0F);

    // random phase against bench model (R2, R3, R4, R5, R8)
    for (int i = 0; i < 600; i++) begin
      if ($urandom_range(3) == 0) ext = 4'($urandom);
      rd_status = ($urandom_range(7) == 0);
      wr_ctrl   = ($urandom_range(15) == 0);
      wr_data   = 8'($urandom);
      tick();
      compare_all("R2 random");
    end
    rd_status = 1'b0; wr_ctrl = 1'b0;

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule